// File: doc/BRIEF.md
# Source Operand Addressing Evaluator

This block sits in the operand stage of a small 16-bit two-operand processor. It takes the instruction word and decodes its 4-bit source register field and 2-bit source mode field. The result is either an operand value that can be used right away or an effective address that the memory sequencer must read. It also reports how many extra bus cycles the source costs, whether the program counter has to step past an extension word, and whether the source register must be written back after a post-increment.

Some register and mode pairs have a special meaning. With R0 as the base, indexed mode becomes PC-relative and post-increment becomes immediate. With R2, indexed mode becomes absolute (zero base). R2 with the two indirect modes, and R3 with every mode, produce hardwired constants and use no memory cycle.

The register-file read address leaves the block combinationally. All results are registered once and appear one clock after the instruction is presented with `valid_i`.

Top module: `src_opnd_eval`

## Requirements
- R1: Field positions are: source register = instr[11:8], source mode = instr[5:4], byte flag = instr[6]. `src_idx_o` equals instr[11:8] in the same cycle. All other outputs are registered and appear with `valid_o` one clock after `valid_i`.
- R2: Mode 0 (register) with R0, R1 or R4..R15 gives a ready operand with 0 extra cycles. The operand is `pc_i` for R0 and `src_val_i` otherwise. R2 in mode 0 passes `src_val_i` (the status register) the same way.
- R3: Mode 1 (indexed) with R1 or R4..R15 requests a read at `src_val_i + ext_i` (modulo 2^16), with 2 extra cycles and `pc_adv_o` high.
- R4: Mode 1 with R0 (PC-relative) requests a read at `pc_i + ext_i`, with 2 extra cycles and `pc_adv_o` high.
- R5: Mode 1 with R2 (absolute) requests a read at `ext_i`, with 2 extra cycles and `pc_adv_o` high.
- R6: Mode 2 (indirect) with R0, R1 or R4..R15 requests a read at the base register value (`pc_i` for R0), with 1 extra cycle. It makes no register write and no PC advance.
- R7: Mode 3 (post-increment) with R1 or R4..R15 requests a read at `src_val_i`, with 1 extra cycle. It writes back register instr[11:8] with `src_val_i + 1` when the byte flag is 1 and `src_val_i + 2` when it is 0, wrapping modulo 2^16.
- R8: Mode 3 with R0 (immediate) gives a ready operand equal to `ext_i`, with 1 extra cycle, `pc_adv_o` high and no register write.
- R9: The constant generator gives R3 modes 0/1/2/3 = 0x0000/0x0001/0x0002/0xFFFF and R2 modes 2/3 = 0x0004/0x0008. These are ready operands with 0 extra cycles, no read, no write and no PC advance.
- R10: While `valid_o` is high, exactly one of `opnd_ready_o` and `mem_rd_o` is high. While `valid_o` is low, `mem_rd_o`, `reg_wr_o` and `pc_adv_o` are low.
- R11: After reset, and until the first valid instruction, every registered output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word present |
| instr_i | input | 16 | Instruction word |
| src_idx_o | output | 4 | Register-file read address (source field) |
| src_val_i | input | 16 | Register-file read data for `src_idx_o` |
| pc_i | input | 16 | PC, pointing at the extension word |
| ext_i | input | 16 | Extension word fetched at `pc_i` |
| valid_o | output | 1 | Result valid |
| opnd_ready_o | output | 1 | Operand available without a data read |
| opnd_o | output | 16 | Operand value when ready |
| mem_rd_o | output | 1 | Data read required |
| mem_addr_o | output | 16 | Effective address of the read |
| extra_cyc_o | output | 2 | Extra bus cycles needed by the source |
| pc_adv_o | output | 1 | PC steps by 2 past the extension word |
| reg_wr_o | output | 1 | Post-increment write-back request |
| reg_wr_idx_o | output | 4 | Register to write back |
| reg_wr_data_o | output | 16 | Incremented register value |

## Verification
On every cycle, the assertions check the following:
- ready and read are mutually exclusive, and nothing is requested while idle;
- a data read always costs bus cycles;
- a PC advance comes only with a 2-cycle source or an immediate;
- the post-increment step matches the byte flag captured one cycle earlier;
- R2/R3 constant forms never read memory.

The exact addresses, constant values and the special R0/R2 reinterpretations can only be confirmed by the bench. It sweeps every register and mode at both operand sizes over several register and extension values, including values that wrap at 0xFFFF.

// File: rtl/sae_pkg.sv
package sae_pkg;
  localparam int SRC_LSB  = 8;
  localparam int MODE_LSB = 4;
  localparam int BYTE_BIT = 6;

  typedef enum logic [1:0] {
    AM_REG = 2'd0,
    AM_IDX = 2'd1,
    AM_IND = 2'd2,
    AM_INC = 2'd3
  } am_e;

  typedef enum logic [2:0] {
    K_REG, K_CONST, K_INDEXED, K_PCREL, K_ABS, K_INDIR, K_POSTINC, K_IMM
  } kind_e;
endpackage

// File: rtl/sae_classify.sv
module sae_classify
  import sae_pkg::*;
#(
  parameter int RW     = 4,
  parameter int PC_IDX = 0,
  parameter int SR_IDX = 2,
  parameter int CG_IDX = 3
) (
  input  logic [RW-1:0] reg_i,
  input  am_e           mode_i,
  output kind_e         kind_o
);
  logic is_pc, is_sr, is_cg;
  assign is_pc = (reg_i == RW'(PC_IDX));
  assign is_sr = (reg_i == RW'(SR_IDX));
  assign is_cg = (reg_i == RW'(CG_IDX));

  always_comb begin
    kind_o = K_REG;
    if (is_cg) begin
      kind_o = K_CONST;
    end else begin
      unique case (mode_i)
        AM_REG: kind_o = K_REG;
        AM_IDX: kind_o = is_pc ? K_PCREL : (is_sr ? K_ABS : K_INDEXED);
        AM_IND: kind_o = is_sr ? K_CONST : K_INDIR;
        AM_INC: kind_o = is_sr ? K_CONST : (is_pc ? K_IMM : K_POSTINC);
        default: kind_o = K_REG;
      endcase
    end
  end
endmodule

// File: rtl/sae_constgen.sv
module sae_constgen
  import sae_pkg::*;
#(
  parameter int DW     = 16,
  parameter int RW     = 4,
  parameter int SR_IDX = 2
) (
  input  logic [RW-1:0] reg_i,
  input  am_e           mode_i,
  output logic [DW-1:0] cval_o
);
  always_comb begin
    if (reg_i == RW'(SR_IDX)) begin
      cval_o = (mode_i == AM_INC) ? DW'(8) : DW'(4);
    end else begin
      unique case (mode_i)
        AM_REG:  cval_o = '0;
        AM_IDX:  cval_o = DW'(1);
        AM_IND:  cval_o = DW'(2);
        default: cval_o = '1;
      endcase
    end
  end
endmodule

// File: rtl/sae_compute.sv
module sae_compute
  import sae_pkg::*;
#(
  parameter int DW = 16
) (
  input  kind_e         kind_i,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] ext_i,
  input  logic [DW-1:0] cval_i,
  input  logic          byte_i,
  output logic          ready_o,
  output logic [DW-1:0] opnd_o,
  output logic          rd_o,
  output logic [DW-1:0] addr_o,
  output logic [1:0]    cyc_o,
  output logic          pc_adv_o,
  output logic          wr_o,
  output logic [DW-1:0] wr_data_o
);
  logic [DW-1:0] step;
  assign step = byte_i ? DW'(1) : DW'(2);

  always_comb begin
    ready_o   = 1'b0;
    opnd_o    = '0;
    rd_o      = 1'b0;
    addr_o    = '0;
    cyc_o     = 2'd0;
    pc_adv_o  = 1'b0;
    wr_o      = 1'b0;
    wr_data_o = '0;
    unique case (kind_i)
      K_REG:   begin ready_o = 1'b1; opnd_o = base_i; end
      K_CONST: begin ready_o = 1'b1; opnd_o = cval_i; end
      K_INDEXED: begin
        rd_o = 1'b1; addr_o = base_i + ext_i; cyc_o = 2'd2; pc_adv_o = 1'b1;
      end
      K_PCREL: begin
        rd_o = 1'b1; addr_o = pc_i + ext_i; cyc_o = 2'd2; pc_adv_o = 1'b1;
      end
      K_ABS: begin
        rd_o = 1'b1; addr_o = ext_i; cyc_o = 2'd2; pc_adv_o = 1'b1;
      end
      K_INDIR: begin rd_o = 1'b1; addr_o = base_i; cyc_o = 2'd1; end
      K_POSTINC: begin
        rd_o = 1'b1; addr_o = base_i; cyc_o = 2'd1;
        wr_o = 1'b1; wr_data_o = base_i + step;
      end
      K_IMM: begin
        ready_o = 1'b1; opnd_o = ext_i; cyc_o = 2'd1; pc_adv_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/src_opnd_eval.sv
module src_opnd_eval
  import sae_pkg::*;
#(
  parameter int DW     = 16,
  parameter int RW     = 4,
  parameter int PC_IDX = 0,
  parameter int SR_IDX = 2,
  parameter int CG_IDX = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] instr_i,
  output logic [RW-1:0] src_idx_o,
  input  logic [DW-1:0] src_val_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] ext_i,
  output logic          valid_o,
  output logic          opnd_ready_o,
  output logic [DW-1:0] opnd_o,
  output logic          mem_rd_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [1:0]    extra_cyc_o,
  output logic          pc_adv_o,
  output logic          reg_wr_o,
  output logic [RW-1:0] reg_wr_idx_o,
  output logic [DW-1:0] reg_wr_data_o
);
  logic [RW-1:0] src_reg;
  am_e           mode;
  logic          is_byte;
  kind_e         kind;
  logic [DW-1:0] base, cval;

  assign src_reg   = instr_i[SRC_LSB +: RW];
  assign mode      = am_e'(instr_i[MODE_LSB +: 2]);
  assign is_byte   = instr_i[BYTE_BIT];
  assign src_idx_o = src_reg;
  // R0 base comes from the fetch PC, not the register file copy
  assign base      = (src_reg == RW'(PC_IDX)) ? pc_i : src_val_i;

  sae_classify #(.RW(RW), .PC_IDX(PC_IDX), .SR_IDX(SR_IDX), .CG_IDX(CG_IDX)) u_cls (
    .reg_i(src_reg), .mode_i(mode), .kind_o(kind)
  );

  sae_constgen #(.DW(DW), .RW(RW), .SR_IDX(SR_IDX)) u_cg (
    .reg_i(src_reg), .mode_i(mode), .cval_o(cval)
  );

  logic          c_ready, c_rd, c_padv, c_wr;
  logic [DW-1:0] c_opnd, c_addr, c_wdata;
  logic [1:0]    c_cyc;

  sae_compute #(.DW(DW)) u_cmp (
    .kind_i(kind), .base_i(base), .pc_i(pc_i), .ext_i(ext_i), .cval_i(cval),
    .byte_i(is_byte), .ready_o(c_ready), .opnd_o(c_opnd), .rd_o(c_rd),
    .addr_o(c_addr), .cyc_o(c_cyc), .pc_adv_o(c_padv), .wr_o(c_wr),
    .wr_data_o(c_wdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o       <= 1'b0;
      opnd_ready_o  <= 1'b0;
      opnd_o        <= '0;
      mem_rd_o      <= 1'b0;
      mem_addr_o    <= '0;
      extra_cyc_o   <= 2'd0;
      pc_adv_o      <= 1'b0;
      reg_wr_o      <= 1'b0;
      reg_wr_idx_o  <= '0;
      reg_wr_data_o <= '0;
    end else begin
      valid_o       <= valid_i;
      opnd_ready_o  <= valid_i & c_ready;
      opnd_o        <= valid_i ? c_opnd : '0;
      mem_rd_o      <= valid_i & c_rd;
      mem_addr_o    <= valid_i ? c_addr : '0;
      extra_cyc_o   <= valid_i ? c_cyc : 2'd0;
      pc_adv_o      <= valid_i & c_padv;
      reg_wr_o      <= valid_i & c_wr;
      reg_wr_idx_o  <= (valid_i & c_wr) ? src_reg : '0;
      reg_wr_data_o <= valid_i ? c_wdata : '0;
    end
  end
endmodule

// File: rtl/src_opnd_eval_chk.sv
module src_opnd_eval_chk #(
  parameter int DW     = 16,
  parameter int RW     = 4,
  parameter int SR_IDX = 2,
  parameter int CG_IDX = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] instr_i,
  input logic          valid_o,
  input logic          opnd_ready_o,
  input logic          mem_rd_o,
  input logic [DW-1:0] mem_addr_o,
  input logic [1:0]    extra_cyc_o,
  input logic          pc_adv_o,
  input logic          reg_wr_o,
  input logic [DW-1:0] reg_wr_data_o
);
  p_ready_xor_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (opnd_ready_o ^ mem_rd_o));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(mem_rd_o || reg_wr_o || pc_adv_o));

  p_read_costs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (extra_cyc_o != 2'd0));

  p_pc_adv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_adv_o |-> ((extra_cyc_o == 2'd2) || (opnd_ready_o && extra_cyc_o == 2'd1)));

  p_postinc_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && reg_wr_o) |->
      (reg_wr_data_o - mem_addr_o == ($past(instr_i[6]) ? DW'(1) : DW'(2))));

  p_const_no_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ($past(instr_i[11:8]) == RW'(CG_IDX))) |-> (opnd_ready_o && !mem_rd_o));

  p_sr_const_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ($past(instr_i[11:8]) == RW'(SR_IDX)) && $past(instr_i[5])) |->
      (opnd_ready_o && extra_cyc_o == 2'd0));
endmodule

bind src_opnd_eval src_opnd_eval_chk #(.DW(DW), .RW(RW), .SR_IDX(SR_IDX), .CG_IDX(CG_IDX)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .instr_i(instr_i), .valid_o(valid_o),
  .opnd_ready_o(opnd_ready_o), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
  .extra_cyc_o(extra_cyc_o), .pc_adv_o(pc_adv_o), .reg_wr_o(reg_wr_o),
  .reg_wr_data_o(reg_wr_data_o)
);

// File: tb/sim_src_opnd_eval.sv
`timescale 1ns/1ps
module sim_src_opnd_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] instr = '0;
  logic [3:0]  src_idx;
  logic [15:0] src_val, pc, ext;
  logic        v_o, rdy_o, rd_o, padv_o, wr_o;
  logic [15:0] opnd_o, addr_o, wdata_o;
  logic [1:0]  cyc_o;
  logic [3:0]  widx_o;
  int          n_chk = 0, n_err = 0, pat = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] reg_model(input int p, input logic [3:0] r);
    case (p)
      0: return 16'h0100 + 16'(r) * 16'h0202;
      1: return 16'hFFFF - 16'(r);
      default: return 16'h8000 ^ 16'(r);
    endcase
  endfunction

  assign src_val = reg_model(pat, src_idx);

  src_opnd_eval u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .src_idx_o(src_idx), .src_val_i(src_val), .pc_i(pc), .ext_i(ext),
    .valid_o(v_o), .opnd_ready_o(rdy_o), .opnd_o(opnd_o), .mem_rd_o(rd_o),
    .mem_addr_o(addr_o), .extra_cyc_o(cyc_o), .pc_adv_o(padv_o),
    .reg_wr_o(wr_o), .reg_wr_idx_o(widx_o), .reg_wr_data_o(wdata_o)
  );

  function automatic logic [71:0] pack_out();
    return {v_o, rdy_o, opnd_o, rd_o, addr_o, cyc_o, padv_o, wr_o, widx_o, wdata_o};
  endfunction

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s instr=%h pat=%0d actual=%h expected=%h", req, instr, pat, act, exp);
    end
  endtask

  task automatic run_one(input logic [3:0] r, input logic [1:0] m, input logic b);
    logic [15:0] rv, e_opnd, e_addr, e_wd;
    logic e_rdy, e_rd, e_padv, e_wr;
    logic [1:0] e_cyc;
    logic [3:0] e_widx;
    string req;
    @(negedge clk);
    instr = 16'h4000 | (16'(r) << 8) | (16'(b) << 6) | (16'(m) << 4) | 16'h0005;
    valid = 1'b1;
    #1;
    n_chk++;
    if (src_idx !== r) begin
      n_err++;
      $display("FAIL R1 src_idx actual=%h expected=%h", src_idx, r);
    end
    rv = (r == 4'd0) ? pc : reg_model(pat, r);
    e_rdy = 0; e_opnd = 0; e_rd = 0; e_addr = 0; e_cyc = 0; e_padv = 0;
    e_wr = 0; e_widx = 0; e_wd = 0; req = "R2";
    if (r == 4'd3 || (r == 4'd2 && m[1])) begin
      req = "R9"; e_rdy = 1;
      if (r == 4'd3) e_opnd = (m == 2'd0) ? 16'h0 : (m == 2'd1) ? 16'h1 : (m == 2'd2) ? 16'h2 : 16'hFFFF;
      else e_opnd = (m == 2'd2) ? 16'h4 : 16'h8;
    end else if (m == 2'd0) begin
      req = "R2"; e_rdy = 1; e_opnd = rv;
    end else if (m == 2'd1) begin
      e_rd = 1; e_cyc = 2; e_padv = 1;
      if (r == 4'd0) begin req = "R4"; e_addr = pc + ext; end
      else if (r == 4'd2) begin req = "R5"; e_addr = ext; end
      else begin req = "R3"; e_addr = rv + ext; end
    end else if (m == 2'd2) begin
      req = "R6"; e_rd = 1; e_cyc = 1; e_addr = rv;
    end else if (r == 4'd0) begin
      req = "R8"; e_rdy = 1; e_opnd = ext; e_cyc = 1; e_padv = 1;
    end else begin
      req = "R7"; e_rd = 1; e_cyc = 1; e_addr = rv; e_wr = 1; e_widx = r;
      e_wd = rv + (b ? 16'd1 : 16'd2);
    end
    @(negedge clk);
    valid = 1'b0;
    check(req, pack_out(),
          {1'b1, e_rdy, e_opnd, e_rd, e_addr, e_cyc, e_padv, e_wr, e_widx, e_wd});
  endtask

  initial begin
    pc = 16'hC000; ext = 16'h0006;
    repeat (3) @(negedge clk);
    check("R11", pack_out(), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", pack_out(), '0);
    for (int p = 0; p < 3; p++) begin
      pat = p;
      pc  = 16'hC000 + 16'(p * 2);
      ext = (p == 0) ? 16'h0006 : (p == 1) ? 16'hFFFE : 16'h7FF0;
      for (int r = 0; r < 16; r++)
        for (int m = 0; m < 4; m++)
          for (int b = 0; b < 2; b++)
            run_one(4'(r), 2'(m), 1'(b));
      @(negedge clk);
      check("R10", pack_out() & {1'b1, 1'b1, 16'h0, 1'b1, 16'h0, 2'b0, 1'b1, 1'b1, 4'h0, 16'h0}, '0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule